// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog that counts ticks from one of two clock-enable sources and raises a reset pulse when software fails to service it in time. Each tick from the selected source first passes through a fixed divide-by-256 stage. The carries from that stage then drive a post-divider, whose ratio is set by a three-bit field in an eight-bit select register. When the post-divider completes its selected span, the block produces a one-cycle reset pulse and the whole counter chain starts again from zero.

Three strap inputs fix the operating options. The first enables the watchdog. The second picks the tick source: a free-running low-speed oscillator tick or the instruction-clock tick. The third chooses between servicing with one clear command and servicing with a pair of distinct commands, which may arrive in either order. Software services the block through the clear strobes. Entering the low-power HALT state, or asserting the external reset, also restarts the chain. An expiry outside HALT requests a full chip reset. An expiry during HALT requests a warm reset instead.

Top module: `wdt_prescaled`

## Requirements
- R1: With the ratio field (select register bits 2:0) equal to s, a pulse appears after exactly 256·N selected ticks counted from the last restart. N is 128 for s=000, 16 for 001, 32 for 010, 64 for 011, 1 for 100, 2 for 101, 4 for 110 and 8 for 111. A register write takes effect from the next cycle.
- R2: Select register bits 7:3 are free flag bits and have no effect on the timeout.
- R3: While `cfg_enable_i` is low, no pulse of either kind is produced, clear strobes have no effect, and the chain is held at zero.
- R4: With `cfg_dual_clr_i` low, a `clr_single_i` strobe restarts the chain. `clr_one_i` and `clr_two_i` are ignored in this mode.
- R5: With `cfg_dual_clr_i` high, the chain restarts only once both `clr_one_i` and `clr_two_i` have been seen, in either order or in the same cycle. Repeating one half alone never restarts it, and `clr_single_i` is ignored in this mode.
- R6: `ext_rst_i` or `halt_enter_i` restarts the chain and discards any half-received dual clear.
- R7: An expiry with `halt_mode_i` low gives a one-cycle `chip_rst_o` pulse, and the chain restarts from zero.
- R8: An expiry with `halt_mode_i` high gives a one-cycle `warm_rst_o` pulse in place of `chip_rst_o`.
- R9: When the instruction tick is the source, the chain does not advance while `halt_mode_i` is high. When the oscillator tick is the source, the chain keeps counting during HALT.
- R10: Only ticks from the source chosen by `cfg_src_instr_i` advance the chain (0 selects `osc_tick_i`, 1 selects `instr_tick_i`).
- R11: Both pulse outputs are low out of reset. A pulse appears in the cycle after the clock edge that samples the final tick, and the two pulses are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low register reset |
| cfg_enable_i | input | 1 | Strap: watchdog enabled |
| cfg_src_instr_i | input | 1 | Strap: 1 selects the instruction tick, 0 selects the oscillator tick |
| cfg_dual_clr_i | input | 1 | Strap: 1 selects two-command clearing |
| osc_tick_i | input | 1 | Low-speed oscillator clock enable |
| instr_tick_i | input | 1 | Instruction clock enable |
| sel_we_i | input | 1 | Select register write strobe |
| sel_wdata_i | input | REG_W | Select register write data |
| clr_single_i | input | 1 | Single clear command |
| clr_one_i | input | 1 | First half of the paired clear |
| clr_two_i | input | 1 | Second half of the paired clear |
| halt_enter_i | input | 1 | Strobe on HALT entry |
| ext_rst_i | input | 1 | External reset request (active high, synchronous) |
| halt_mode_i | input | 1 | High while in HALT |
| chip_rst_o | output | 1 | One-cycle full chip reset request |
| warm_rst_o | output | 1 | One-cycle warm reset request |

## Verification
The assertions take for granted that the straps hold still apart from deliberate changes made between test phases, and that the select register is only rewritten in the same cycle as a restart. They also take for granted that no two expiries can fall on adjacent cycles, which holds because a span is never shorter than 256 ticks. The stimulus pairs every register write with an `ext_rst_i` strobe, so the ratio never shrinks under a partly counted span. Strobes last one cycle and come at least a few cycles apart, so each expiry and each restart is checked in isolation.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int SEL_W  = 3;
    localparam int POST_W = 7;

    typedef logic [SEL_W-1:0] sel_t;

    typedef struct packed {
        logic chip;
        logic warm;
    } pulse_t;

    // Ratio code to log2 of the post-divider ratio.
    function automatic logic [2:0] sel_to_exp(sel_t s);
        logic [2:0] e;
        if (s[2]) begin
            e = {1'b0, s[1:0]};
        end else if (s[1:0] == 2'b00) begin
            e = 3'd7;
        end else begin
            e = {1'b0, s[1:0]} + 3'd3;
        end
        return e;
    endfunction

endpackage

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel (
    input  logic osc_tick_i,
    input  logic instr_tick_i,
    input  logic src_instr_i,
    input  logic halt_mode_i,
    output logic tick_o
);
    logic instr_gated;

    // The instruction clock stops in HALT, so its ticks are dropped there.
    always_comb begin
        instr_gated = instr_tick_i & ~halt_mode_i;
        tick_o      = src_instr_i ? instr_gated : osc_tick_i;
    end
endmodule

// File: rtl/wdt_clear_seq.sv
module wdt_clear_seq (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic enable_i,
    input  logic dual_i,
    input  logic flush_i,
    input  logic clr_single_i,
    input  logic clr_one_i,
    input  logic clr_two_i,
    output logic accept_o
);
    typedef struct packed {
        logic got_one;
        logic got_two;
    } pend_t;

    pend_t state_d, state_q;
    logic  seen_one, seen_two;

    always_comb begin
        state_d  = state_q;
        seen_one = state_q.got_one | clr_one_i;
        seen_two = state_q.got_two | clr_two_i;
        if (dual_i) begin
            accept_o = enable_i & seen_one & seen_two;
        end else begin
            accept_o = enable_i & clr_single_i;
        end

        if (!enable_i || !dual_i || flush_i || accept_o) begin
            state_d = '0;
        end else begin
            state_d.got_one = seen_one;
            state_d.got_two = seen_two;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/wdt_chain.sv
module wdt_chain #(
    parameter int PRE_W  = 8,
    parameter int POST_W = 7
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              enable_i,
    input  logic              restart_i,
    input  logic              tick_i,
    input  logic [POST_W-1:0] term_i,
    output logic              overflow_o,
    output logic [PRE_W-1:0]  pre_o,
    output logic [POST_W-1:0] post_o
);
    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [POST_W-1:0] post;
    } chain_t;

    chain_t         state_d, state_q;
    logic [PRE_W:0] carry;

    // Ripple carry through the fixed pre-divider stages.
    assign carry[0] = 1'b1;
    generate
        for (genvar g = 0; g < PRE_W; g++) begin : g_stage
            assign carry[g+1] = carry[g] & state_q.pre[g];
        end
    endgenerate

    always_comb begin
        state_d    = state_q;
        overflow_o = 1'b0;
        if (!enable_i || restart_i) begin
            state_d = '0;
        end else if (tick_i) begin
            state_d.pre = state_q.pre + 1'b1;
            if (carry[PRE_W]) begin
                if (state_q.post >= term_i) begin
                    overflow_o   = 1'b1;
                    state_d.post = '0;
                end else begin
                    state_d.post = state_q.post + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pre_o  = state_q.pre;
    assign post_o = state_q.post;
endmodule

// File: rtl/wdt_prescaled.sv
module wdt_prescaled #(
    parameter int PRE_W = 8,
    parameter int REG_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_enable_i,
    input  logic             cfg_src_instr_i,
    input  logic             cfg_dual_clr_i,
    input  logic             osc_tick_i,
    input  logic             instr_tick_i,
    input  logic             sel_we_i,
    input  logic [REG_W-1:0] sel_wdata_i,
    input  logic             clr_single_i,
    input  logic             clr_one_i,
    input  logic             clr_two_i,
    input  logic             halt_enter_i,
    input  logic             ext_rst_i,
    input  logic             halt_mode_i,
    output logic             chip_rst_o,
    output logic             warm_rst_o
);
    import wdt_pkg::*;

    localparam int POST_W_L = wdt_pkg::POST_W;
    localparam int SEL_W_L  = wdt_pkg::SEL_W;

    typedef struct packed {
        logic [REG_W-1:0] sel;
        pulse_t           pulse;
    } top_t;

    top_t                state_d, state_q;
    logic                tick;
    logic                flush;
    logic                accept;
    logic                restart;
    logic                overflow;
    logic [2:0]          ratio_exp;
    logic [POST_W_L-1:0] term_post;
    logic [PRE_W-1:0]    chain_pre;
    logic [POST_W_L-1:0] chain_post;
    logic                unused_flag_bits;

    assign unused_flag_bits = ^state_q.sel[REG_W-1:SEL_W_L];

    wdt_tick_sel u_tick (
        .osc_tick_i   (osc_tick_i),
        .instr_tick_i (instr_tick_i),
        .src_instr_i  (cfg_src_instr_i),
        .halt_mode_i  (halt_mode_i),
        .tick_o       (tick)
    );

    assign flush = ext_rst_i | halt_enter_i;

    wdt_clear_seq u_clr (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .enable_i     (cfg_enable_i),
        .dual_i       (cfg_dual_clr_i),
        .flush_i      (flush),
        .clr_single_i (clr_single_i),
        .clr_one_i    (clr_one_i),
        .clr_two_i    (clr_two_i),
        .accept_o     (accept)
    );

    assign restart = flush | accept;

    // Terminal post-divider count: ratio minus one, as a run of low ones.
    always_comb begin
        ratio_exp = sel_to_exp(state_q.sel[SEL_W_L-1:0]);
        for (int i = 0; i < POST_W_L; i++) begin
            term_post[i] = (i < int'(ratio_exp));
        end
    end

    wdt_chain #(
        .PRE_W  (PRE_W),
        .POST_W (POST_W_L)
    ) u_chain (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .enable_i   (cfg_enable_i),
        .restart_i  (restart),
        .tick_i     (tick),
        .term_i     (term_post),
        .overflow_o (overflow),
        .pre_o      (chain_pre),
        .post_o     (chain_post)
    );

    always_comb begin
        state_d            = state_q;
        state_d.pulse.chip = overflow & ~halt_mode_i;
        state_d.pulse.warm = overflow & halt_mode_i;
        if (sel_we_i) begin
            state_d.sel = sel_wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign chip_rst_o = state_q.pulse.chip;
    assign warm_rst_o = state_q.pulse.warm;
endmodule

// File: rtl/wdt_prescaled_chk.sv
module wdt_prescaled_chk #(
    parameter int PRE_W  = 8,
    parameter int POST_W = 7
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cfg_enable_i,
    input logic              cfg_src_instr_i,
    input logic              clr_single_i,
    input logic              clr_one_i,
    input logic              clr_two_i,
    input logic              halt_enter_i,
    input logic              ext_rst_i,
    input logic              halt_mode_i,
    input logic              chip_rst_o,
    input logic              warm_rst_o,
    input logic [PRE_W-1:0]  pre_i,
    input logic [POST_W-1:0] post_i
);
    // R3: a disabled watchdog never requests a reset
    assert_off_silent_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_enable_i |=> (!chip_rst_o && !warm_rst_o));

    // R11: the two requests are mutually exclusive
    assert_pulse_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(chip_rst_o && warm_rst_o));

    // R7: chip request lasts one cycle
    assert_chip_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chip_rst_o |=> !chip_rst_o);

    // R8: warm request lasts one cycle
    assert_warm_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        warm_rst_o |=> !warm_rst_o);

    // R8: a warm request only follows a cycle spent in HALT
    assert_warm_in_halt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        warm_rst_o |-> $past(halt_mode_i));

    // R7: a chip request only follows a cycle outside HALT
    assert_chip_outside_halt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chip_rst_o |-> !$past(halt_mode_i));

    // R7: the chain is back at zero when a request is seen
    assert_restart_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (chip_rst_o || warm_rst_o) |-> (pre_i == '0 && post_i == '0));

    // R6: an external reset empties the chain
    assert_ext_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ext_rst_i |=> (pre_i == '0 && post_i == '0));

    // R9: instruction-clocked chain is frozen in HALT
    assert_instr_freeze_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_enable_i && cfg_src_instr_i && halt_mode_i && !ext_rst_i && !halt_enter_i
         && !clr_single_i && !clr_one_i && !clr_two_i)
        |=> ($stable(pre_i) && $stable(post_i)));
endmodule

bind wdt_prescaled wdt_prescaled_chk #(
    .PRE_W  (PRE_W),
    .POST_W (POST_W_L)
) u_wdt_chk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .cfg_enable_i    (cfg_enable_i),
    .cfg_src_instr_i (cfg_src_instr_i),
    .clr_single_i    (clr_single_i),
    .clr_one_i       (clr_one_i),
    .clr_two_i       (clr_two_i),
    .halt_enter_i    (halt_enter_i),
    .ext_rst_i       (ext_rst_i),
    .halt_mode_i     (halt_mode_i),
    .chip_rst_o      (chip_rst_o),
    .warm_rst_o      (warm_rst_o),
    .pre_i           (chain_pre),
    .post_i          (chain_post)
);

// File: tb/tb_wdt_prescaled.sv
module tb_wdt_prescaled;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1, src_instr = 1'b0, dual = 1'b0;
    logic       osc_tick = 1'b0, instr_tick = 1'b0;
    logic       we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       c_single = 1'b0, c_one = 1'b0, c_two = 1'b0;
    logic       halt_en = 1'b0, ext = 1'b0, halt = 1'b0;
    logic       chip, warm;

    int    compared = 0, mismatched = 0;
    int    osc_per = 1, instr_per = 0, cyc_idx = 0;
    string cur_req = "R11";
    bit    done = 0;

    // Reference state
    int       m_cnt = 0;
    bit       m_p1 = 0, m_p2 = 0;
    bit [7:0] m_sel = 0;
    bit       e_chip = 0, e_warm = 0;

    always #5 clk = ~clk;

    wdt_prescaled dut (
        .clk_i(clk), .rst_ni(rst_n),
        .cfg_enable_i(en), .cfg_src_instr_i(src_instr), .cfg_dual_clr_i(dual),
        .osc_tick_i(osc_tick), .instr_tick_i(instr_tick),
        .sel_we_i(we), .sel_wdata_i(wdata),
        .clr_single_i(c_single), .clr_one_i(c_one), .clr_two_i(c_two),
        .halt_enter_i(halt_en), .ext_rst_i(ext), .halt_mode_i(halt),
        .chip_rst_o(chip), .warm_rst_o(warm)
    );

    // Ratio table as written in R1
    function automatic int ratio_of(bit [7:0] r);
        case (r[2:0])
            3'b000: return 128;
            3'b001: return 16;
            3'b010: return 32;
            3'b011: return 64;
            3'b100: return 1;
            3'b101: return 2;
            3'b110: return 4;
            default: return 8;
        endcase
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    task automatic cyc();
        bit t, acc;
        osc_tick   = (osc_per   > 0) && (cyc_idx % osc_per   == 0);
        instr_tick = (instr_per > 0) && (cyc_idx % instr_per == 0);
        cyc_idx++;
        @(posedge clk);
        e_chip = 0; e_warm = 0;
        if (!rst_n) begin
            m_cnt = 0; m_p1 = 0; m_p2 = 0; m_sel = 0;
        end else begin
            t = src_instr ? (instr_tick && !halt) : osc_tick;
            if (!en) begin
                m_cnt = 0; m_p1 = 0; m_p2 = 0;
            end else begin
                acc = dual ? ((m_p1 || c_one) && (m_p2 || c_two)) : c_single;
                if (ext || halt_en || acc) begin
                    m_cnt = 0; m_p1 = 0; m_p2 = 0;
                end else begin
                    if (dual) begin
                        m_p1 = m_p1 || c_one;
                        m_p2 = m_p2 || c_two;
                    end else begin
                        m_p1 = 0; m_p2 = 0;
                    end
                    if (t) begin
                        m_cnt++;
                        if (m_cnt >= 256 * ratio_of(m_sel)) begin
                            m_cnt = 0;
                            if (halt) e_warm = 1; else e_chip = 1;
                        end
                    end
                end
            end
            if (we) m_sel = wdata;
        end
        #1;
        compared++;
        if (chip !== e_chip || warm !== e_warm) begin
            mismatched++;
            $display("FAIL %s cycle %0d: chip/warm actual %b%b expected %b%b",
                     cur_req, cyc_idx, chip, warm, e_chip, e_warm);
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    // Register write always paired with a restart, so the ratio never shrinks mid-span.
    task automatic wr_sel(bit [7:0] v);
        we = 1; wdata = v; ext = 1;
        cyc();
        we = 0; ext = 0;
    endtask

    task automatic pulse_single(); c_single = 1; cyc(); c_single = 0; endtask
    task automatic pulse_one();    c_one = 1;    cyc(); c_one = 0;    endtask
    task automatic pulse_two();    c_two = 1;    cyc(); c_two = 0;    endtask
    task automatic pulse_ext();    ext = 1;      cyc(); ext = 0;      endtask
    task automatic pulse_halt();   halt_en = 1;  cyc(); halt_en = 0;  endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 199000) begin
                mismatched++;
                $display("FAIL watchdog: run did not finish, actual hung expected done");
                summary();
            end
        end
    end

    initial begin
        // R11: reset state
        cur_req = "R11";
        run(4);
        rst_n = 1;
        run(3);

        // R1: every ratio code, oscillator source, single mode
        cur_req = "R1";
        for (int s = 0; s < 8; s++) begin
            bit [2:0] code = 3'(s + 4);
            wr_sel({5'b0, code});
            run(256 * ratio_of({5'b0, code}) + 4);
        end

        // R2: flag bits do not change the span
        cur_req = "R2";
        wr_sel(8'hFC);
        run(600);
        wr_sel(8'h0D);
        run(1100);

        // R4: single clear restarts, paired halves ignored
        cur_req = "R4";
        wr_sel(8'h04);
        run(200);
        pulse_single();
        run(300);
        run(100);
        pulse_one();
        run(60);
        pulse_two();
        run(200);

        // R7: chain restarts after an expiry (back-to-back spans)
        cur_req = "R7";
        run(520);

        // R10: sparse oscillator ticks, instruction ticks must not count
        cur_req = "R10";
        osc_per = 3; instr_per = 1;
        pulse_ext();
        run(800);
        src_instr = 1; osc_per = 1; instr_per = 2;
        pulse_ext();
        run(600);

        // R9: instruction source frozen in HALT, resumes after
        cur_req = "R9";
        instr_per = 1;
        pulse_ext();
        run(100);
        halt = 1;
        run(400);
        halt = 0;
        run(200);

        // R8: oscillator source keeps counting in HALT and gives a warm reset
        cur_req = "R8";
        src_instr = 0; osc_per = 1;
        halt = 1;
        pulse_halt();
        run(300);
        halt = 0;
        run(300);

        // R6: external reset and HALT entry restart the span
        cur_req = "R6";
        run(150);
        pulse_ext();
        run(200);
        pulse_halt();
        run(300);

        // R5: paired clearing
        cur_req = "R5";
        dual = 1;
        pulse_ext();
        run(100);
        pulse_one();
        run(50);
        pulse_one();
        run(150);
        pulse_single();
        run(100);
        pulse_two();
        run(60);
        pulse_one();
        run(200);
        c_one = 1; c_two = 1; cyc(); c_one = 0; c_two = 0;
        run(200);
        run(100);
        // R6: a pending half is discarded by a restart
        cur_req = "R6";
        pulse_one();
        run(20);
        pulse_ext();
        run(20);
        pulse_two();
        run(250);
        pulse_two();
        run(20);
        pulse_halt();
        run(20);
        pulse_one();
        run(260);

        // R3: disabled watchdog stays silent
        cur_req = "R3";
        dual = 0;
        en = 0;
        run(300);
        pulse_single();
        run(300);
        en = 1;
        run(300);

        summary();
    end
endmodule